// File: doc/BRIEF.md
# Combining Fetch-and-Add Switch Node

This block is one two-by-two element of a combining interconnect that sits between processors and a shared memory. Processors issue atomic fetch-and-add requests. Each request carries a unique tag, a word address and an increment, and the requester expects the word's previous value back. Requests enter on an upper port and a lower port and leave towards memory on a single forward port. Replies come back from memory on one reply port and are steered to the two requester-side reply ports.

When both inputs offer a request to the same address in the same cycle and the internal pending table has a free slot, the node merges the two requests into one. The merged request carries the upper requester's tag and the sum of both increments, and the upper increment is kept in the table. When memory answers that tag, the node splits the reply. The upper requester gets the value memory returned, and the lower requester gets that value plus the kept increment. The outcome is the same as if the upper request had executed first and the lower one right after it. A reply whose tag has no table entry is sent, unchanged, to the port that issued that tag. Every channel uses a valid/ready handshake, and the node can be cascaded into multi-stage trees.

Top module: `faa_combine_node`

## Requirements
- R1: When both inputs are valid with equal addresses, the forward slot can load, and the pending table is not full, both inputs are accepted in the same cycle. On the next cycle the forward port presents the upper tag, the shared address and the sum of both increments.
- R2: When both inputs are valid with different addresses, only the upper input is accepted in that cycle (lower ready low). The lower request is forwarded in a later cycle, so at most one request is forwarded per cycle.
- R3: With all pending-table slots occupied, no merge occurs: a same-address pair is forwarded as two separate requests, the upper one first and each with its own increment.
- R4: A memory reply whose tag matches a pending-table slot produces, one cycle after acceptance, the returned value with the upper tag on reply port 0 and the returned value plus the kept upper increment with the lower tag on reply port 1. The slot is then freed.
- R5: A memory reply whose tag matches no slot is delivered with tag and data unchanged, one cycle after acceptance, only on the reply port (0 upper, 1 lower) whose input issued that tag.
- R6: While the forward port is valid and not accepted, its valid, tag, address and increment stay unchanged.
- R7: While a reply port is valid and not accepted, its valid, tag and data stay unchanged. The memory reply is not accepted while any reply port it needs is occupied.
- R8: Over any traffic, each address ends at its initial value plus all increments applied to it. The values returned for each address are exactly the running prefix sums of one serial order of its requests.
- R9: After reset, the forward port and both reply ports are not valid and the upper input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req0_valid | input | 1 | Upper request valid |
| req0_ready | output | 1 | Upper request accepted |
| req0_id | input | ID_W | Upper request tag |
| req0_addr | input | ADDR_W | Upper request address |
| req0_inc | input | DATA_W | Upper request increment |
| req1_valid | input | 1 | Lower request valid |
| req1_ready | output | 1 | Lower request accepted |
| req1_id | input | ID_W | Lower request tag |
| req1_addr | input | ADDR_W | Lower request address |
| req1_inc | input | DATA_W | Lower request increment |
| fwd_valid | output | 1 | Forwarded request valid |
| fwd_ready | input | 1 | Memory side accepts forwarded request |
| fwd_id | output | ID_W | Forwarded tag |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_inc | output | DATA_W | Forwarded (possibly summed) increment |
| mrsp_valid | input | 1 | Memory reply valid |
| mrsp_ready | output | 1 | Memory reply accepted |
| mrsp_id | input | ID_W | Memory reply tag |
| mrsp_data | input | DATA_W | Previous memory value |
| rsp0_valid | output | 1 | Upper reply valid |
| rsp0_ready | input | 1 | Upper reply accepted |
| rsp0_id | output | ID_W | Upper reply tag |
| rsp0_data | output | DATA_W | Upper reply value |
| rsp1_valid | output | 1 | Lower reply valid |
| rsp1_ready | input | 1 | Lower reply accepted |
| rsp1_id | output | ID_W | Lower reply tag |
| rsp1_data | output | DATA_W | Lower reply value |

## Verification
The bench builds the node with ID_W=5, ADDR_W=3, DATA_W=16 and a two-slot pending table, not the default four. The smaller table fills after only two unanswered merges, which lets the directed part reach the no-merge path cheaply and lets the random part switch often between merging and plain forwarding. Random traffic is aimed at four addresses, so same-address collisions are frequent. With 32 tags split into even and odd sets, one per input, any reply sent to the wrong port is visible at once.

// File: rtl/faa_pkg.sv
package faa_pkg;

   typedef enum logic {
      PORT_UP = 1'b0,
      PORT_LO = 1'b1
   } faa_port_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/faa_fwd_arb.sv
module faa_fwd_arb
   import faa_pkg::*;
#(
   parameter int unsigned ID_W   = 4,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req0_valid,
   output logic              req0_ready,
   input  logic [ID_W-1:0]   req0_id,
   input  logic [ADDR_W-1:0] req0_addr,
   input  logic [DATA_W-1:0] req0_inc,
   input  logic              req1_valid,
   output logic              req1_ready,
   input  logic [ID_W-1:0]   req1_id,
   input  logic [ADDR_W-1:0] req1_addr,
   input  logic [DATA_W-1:0] req1_inc,
   input  logic              wb_full,
   output logic              wb_alloc,
   output logic              route_we,
   output logic [ID_W-1:0]   route_id,
   output faa_port_e         route_port,
   output logic              fwd_valid,
   input  logic              fwd_ready,
   output logic [ID_W-1:0]   fwd_id,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic [DATA_W-1:0] fwd_inc
);

   logic              load_en;
   logic              merge;
   logic              take0;
   logic              take1;
   logic              fwd_valid_q;
   logic [ID_W-1:0]   fwd_id_q;
   logic [ADDR_W-1:0] fwd_addr_q;
   logic [DATA_W-1:0] fwd_inc_q;

   assign load_en    = !fwd_valid_q || fwd_ready;
   assign merge      = req0_valid && req1_valid && (req0_addr == req1_addr) && !wb_full;
   assign req0_ready = load_en;
   assign req1_ready = load_en && (!req0_valid || merge);
   assign take0      = req0_valid && load_en;
   assign take1      = req1_valid && req1_ready;
   assign wb_alloc   = merge && load_en;

   always_comb begin
      route_we   = take0 || take1;
      route_id   = take0 ? req0_id : req1_id;
      route_port = take0 ? PORT_UP : PORT_LO;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_valid_q <= 1'b0;
      end else if (load_en) begin
         fwd_valid_q <= take0 || take1;
      end
   end

   always_ff @(posedge clk) begin
      if (take0) begin
         fwd_id_q   <= req0_id;
         fwd_addr_q <= req0_addr;
         fwd_inc_q  <= merge ? (req0_inc + req1_inc) : req0_inc;
      end else if (take1) begin
         fwd_id_q   <= req1_id;
         fwd_addr_q <= req1_addr;
         fwd_inc_q  <= req1_inc;
      end
   end

   assign fwd_valid = fwd_valid_q;
   assign fwd_id    = fwd_id_q;
   assign fwd_addr  = fwd_addr_q;
   assign fwd_inc   = fwd_inc_q;

   AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_id) && $stable(fwd_addr) && $stable(fwd_inc)); // R6

   AST_MERGE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      req0_valid && req0_ready && req1_valid && req1_ready
      |=> fwd_valid && fwd_id == $past(req0_id) && fwd_inc == ($past(req0_inc) + $past(req1_inc))); // R1

   AST_UPPER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      req0_valid && req1_valid && (req0_addr != req1_addr) |-> !req1_ready); // R2

endmodule

// File: rtl/faa_wait_buf.sv
module faa_wait_buf
   import faa_pkg::*;
#(
   parameter int unsigned ID_W   = 4,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [ID_W-1:0]   alloc_fid,
   input  logic [ID_W-1:0]   alloc_oid,
   input  logic [DATA_W-1:0] alloc_inc,
   output logic              full,
   input  logic [ID_W-1:0]   look_id,
   output logic              hit,
   output logic [ID_W-1:0]   hit_oid,
   output logic [DATA_W-1:0] hit_inc,
   input  logic              free
);

   localparam int unsigned IDX_W = idx_width(DEPTH);

   logic              ent_vld [DEPTH];
   logic [ID_W-1:0]   ent_fid [DEPTH];
   logic [ID_W-1:0]   ent_oid [DEPTH];
   logic [DATA_W-1:0] ent_inc [DEPTH];
   logic [IDX_W-1:0]  alloc_sel;
   logic [IDX_W-1:0]  hit_sel;

   always_comb begin
      full      = 1'b1;
      alloc_sel = '0;
      for (int e = DEPTH - 1; e >= 0; e--) begin
         if (!ent_vld[e]) begin
            full      = 1'b0;
            alloc_sel = IDX_W'(e);
         end
      end
   end

   always_comb begin
      hit     = 1'b0;
      hit_sel = '0;
      for (int e = 0; e < DEPTH; e++) begin
         if (ent_vld[e] && ent_fid[e] == look_id) begin
            hit     = 1'b1;
            hit_sel = IDX_W'(e);
         end
      end
   end

   assign hit_oid = ent_oid[hit_sel];
   assign hit_inc = ent_inc[hit_sel];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_vld[e] <= 1'b0;
         end else if (alloc && alloc_sel == IDX_W'(e)) begin
            ent_vld[e] <= 1'b1;
         end else if (free && hit_sel == IDX_W'(e)) begin
            ent_vld[e] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (alloc && alloc_sel == IDX_W'(e)) begin
            ent_fid[e] <= alloc_fid;
            ent_oid[e] <= alloc_oid;
            ent_inc[e] <= alloc_inc;
         end
      end
   end

   AST_WB_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> !full); // R3

   AST_FREE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      free |-> hit); // R4

endmodule

// File: rtl/faa_rsp_split.sv
module faa_rsp_split
   import faa_pkg::*;
#(
   parameter int unsigned ID_W   = 4,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mrsp_valid,
   output logic              mrsp_ready,
   input  logic [ID_W-1:0]   mrsp_id,
   input  logic [DATA_W-1:0] mrsp_data,
   input  logic              wb_hit,
   input  logic [ID_W-1:0]   wb_oid,
   input  logic [DATA_W-1:0] wb_inc,
   input  faa_port_e         home_port,
   output logic              wb_free,
   output logic              rsp0_valid,
   input  logic              rsp0_ready,
   output logic [ID_W-1:0]   rsp0_id,
   output logic [DATA_W-1:0] rsp0_data,
   output logic              rsp1_valid,
   input  logic              rsp1_ready,
   output logic [ID_W-1:0]   rsp1_id,
   output logic [DATA_W-1:0] rsp1_data
);

   logic              slot0_free;
   logic              slot1_free;
   logic              accept;
   logic              ld0;
   logic              ld1;
   logic              v0_q;
   logic              v1_q;
   logic [ID_W-1:0]   id0_q;
   logic [ID_W-1:0]   id1_q;
   logic [DATA_W-1:0] d0_q;
   logic [DATA_W-1:0] d1_q;

   assign slot0_free = !v0_q || rsp0_ready;
   assign slot1_free = !v1_q || rsp1_ready;

   always_comb begin
      if (wb_hit) begin
         mrsp_ready = slot0_free && slot1_free;
      end else if (home_port == PORT_LO) begin
         mrsp_ready = slot1_free;
      end else begin
         mrsp_ready = slot0_free;
      end
   end

   assign accept  = mrsp_valid && mrsp_ready;
   assign ld0     = accept && (wb_hit || home_port == PORT_UP);
   assign ld1     = accept && (wb_hit || home_port == PORT_LO);
   assign wb_free = accept && wb_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v0_q <= 1'b0;
         v1_q <= 1'b0;
      end else begin
         v0_q <= ld0 || (v0_q && !rsp0_ready);
         v1_q <= ld1 || (v1_q && !rsp1_ready);
      end
   end

   always_ff @(posedge clk) begin
      if (ld0) begin
         id0_q <= mrsp_id;
         d0_q  <= mrsp_data;
      end
      if (ld1) begin
         id1_q <= wb_hit ? wb_oid : mrsp_id;
         d1_q  <= wb_hit ? (mrsp_data + wb_inc) : mrsp_data;
      end
   end

   assign rsp0_valid = v0_q;
   assign rsp0_id    = id0_q;
   assign rsp0_data  = d0_q;
   assign rsp1_valid = v1_q;
   assign rsp1_id    = id1_q;
   assign rsp1_data  = d1_q;

   AST_RSP0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp0_valid && !rsp0_ready |=> rsp0_valid && $stable(rsp0_id) && $stable(rsp0_data)); // R7

   AST_RSP1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp1_valid && !rsp1_ready |=> rsp1_valid && $stable(rsp1_id) && $stable(rsp1_data)); // R7

   AST_SPLIT_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
      mrsp_valid && mrsp_ready && wb_hit
      |=> rsp0_valid && rsp1_valid && rsp0_data == $past(mrsp_data)
          && rsp1_data == ($past(mrsp_data) + $past(wb_inc))); // R4

   AST_MISS_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      mrsp_valid && mrsp_ready && !wb_hit |=> (rsp0_valid && rsp0_id == $past(mrsp_id)) != (rsp1_valid && rsp1_id == $past(mrsp_id)) || (rsp0_id == rsp1_id)); // R5

endmodule

// File: rtl/faa_combine_node.sv
module faa_combine_node
   import faa_pkg::*;
#(
   parameter int unsigned ID_W     = 4,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned WB_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req0_valid,
   output logic              req0_ready,
   input  logic [ID_W-1:0]   req0_id,
   input  logic [ADDR_W-1:0] req0_addr,
   input  logic [DATA_W-1:0] req0_inc,
   input  logic              req1_valid,
   output logic              req1_ready,
   input  logic [ID_W-1:0]   req1_id,
   input  logic [ADDR_W-1:0] req1_addr,
   input  logic [DATA_W-1:0] req1_inc,
   output logic              fwd_valid,
   input  logic              fwd_ready,
   output logic [ID_W-1:0]   fwd_id,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic [DATA_W-1:0] fwd_inc,
   input  logic              mrsp_valid,
   output logic              mrsp_ready,
   input  logic [ID_W-1:0]   mrsp_id,
   input  logic [DATA_W-1:0] mrsp_data,
   output logic              rsp0_valid,
   input  logic              rsp0_ready,
   output logic [ID_W-1:0]   rsp0_id,
   output logic [DATA_W-1:0] rsp0_data,
   output logic              rsp1_valid,
   input  logic              rsp1_ready,
   output logic [ID_W-1:0]   rsp1_id,
   output logic [DATA_W-1:0] rsp1_data
);

   localparam int unsigned TAGS = 1 << ID_W;

   if (ID_W < 1 || ID_W > 10) begin : g_bad_id
      $error("ID_W must lie in 1..10");
   end
   if (WB_DEPTH < 1 || WB_DEPTH > 64) begin : g_bad_depth
      $error("WB_DEPTH must lie in 1..64");
   end
   if (DATA_W < 2 || ADDR_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 2 and ADDR_W at least 1");
   end

   logic              wb_full;
   logic              wb_alloc;
   logic              wb_hit;
   logic              wb_free;
   logic [ID_W-1:0]   wb_oid;
   logic [DATA_W-1:0] wb_inc;
   logic              route_we;
   logic [ID_W-1:0]   route_id;
   faa_port_e         route_port;
   faa_port_e         home_q [TAGS];
   faa_port_e         home_port;

   faa_fwd_arb #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .req0_valid (req0_valid),
      .req0_ready (req0_ready),
      .req0_id    (req0_id),
      .req0_addr  (req0_addr),
      .req0_inc   (req0_inc),
      .req1_valid (req1_valid),
      .req1_ready (req1_ready),
      .req1_id    (req1_id),
      .req1_addr  (req1_addr),
      .req1_inc   (req1_inc),
      .wb_full    (wb_full),
      .wb_alloc   (wb_alloc),
      .route_we   (route_we),
      .route_id   (route_id),
      .route_port (route_port),
      .fwd_valid  (fwd_valid),
      .fwd_ready  (fwd_ready),
      .fwd_id     (fwd_id),
      .fwd_addr   (fwd_addr),
      .fwd_inc    (fwd_inc)
   );

   faa_wait_buf #(.ID_W(ID_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (wb_alloc),
      .alloc_fid (req0_id),
      .alloc_oid (req1_id),
      .alloc_inc (req0_inc),
      .full      (wb_full),
      .look_id   (mrsp_id),
      .hit       (wb_hit),
      .hit_oid   (wb_oid),
      .hit_inc   (wb_inc),
      .free      (wb_free)
   );

   always_ff @(posedge clk) begin
      if (route_we) begin
         home_q[route_id] <= route_port;
      end
   end

   assign home_port = home_q[mrsp_id];

   faa_rsp_split #(.ID_W(ID_W), .DATA_W(DATA_W)) u_split (
      .clk        (clk),
      .rst_n      (rst_n),
      .mrsp_valid (mrsp_valid),
      .mrsp_ready (mrsp_ready),
      .mrsp_id    (mrsp_id),
      .mrsp_data  (mrsp_data),
      .wb_hit     (wb_hit),
      .wb_oid     (wb_oid),
      .wb_inc     (wb_inc),
      .home_port  (home_port),
      .wb_free    (wb_free),
      .rsp0_valid (rsp0_valid),
      .rsp0_ready (rsp0_ready),
      .rsp0_id    (rsp0_id),
      .rsp0_data  (rsp0_data),
      .rsp1_valid (rsp1_valid),
      .rsp1_ready (rsp1_ready),
      .rsp1_id    (rsp1_id),
      .rsp1_data  (rsp1_data)
   );

   AST_ONE_FWD_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req1_valid && req1_ready && req0_valid |-> req0_ready && req0_addr == req1_addr); // R2

endmodule

// File: tb/sim_faa_combine_node.sv
`timescale 1ns/1ps
module sim_faa_combine_node;

   localparam int ID_W   = 5;
   localparam int ADDR_W = 3;
   localparam int DATA_W = 16;
   localparam int WBD    = 2;
   localparam int NTAG   = 1 << ID_W;
   localparam int NPORT  = 150;
   localparam int NREC   = 2 * NPORT;
   localparam int LIMIT  = 60000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req0_valid = 1'b0, req1_valid = 1'b0;
   logic              req0_ready, req1_ready;
   logic [ID_W-1:0]   req0_id = '0, req1_id = '0;
   logic [ADDR_W-1:0] req0_addr = '0, req1_addr = '0;
   logic [DATA_W-1:0] req0_inc = '0, req1_inc = '0;
   logic              fwd_valid, fwd_ready = 1'b0;
   logic [ID_W-1:0]   fwd_id;
   logic [ADDR_W-1:0] fwd_addr;
   logic [DATA_W-1:0] fwd_inc;
   logic              mrsp_valid = 1'b0, mrsp_ready;
   logic [ID_W-1:0]   mrsp_id = '0;
   logic [DATA_W-1:0] mrsp_data = '0;
   logic              rsp0_valid, rsp1_valid;
   logic              rsp0_ready = 1'b1, rsp1_ready = 1'b1;
   logic [ID_W-1:0]   rsp0_id, rsp1_id;
   logic [DATA_W-1:0] rsp0_data, rsp1_data;

   always #10 clk = ~clk;

   faa_combine_node #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WB_DEPTH(WBD)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req0_valid(req0_valid), .req0_ready(req0_ready), .req0_id(req0_id),
      .req0_addr(req0_addr), .req0_inc(req0_inc),
      .req1_valid(req1_valid), .req1_ready(req1_ready), .req1_id(req1_id),
      .req1_addr(req1_addr), .req1_inc(req1_inc),
      .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_id(fwd_id),
      .fwd_addr(fwd_addr), .fwd_inc(fwd_inc),
      .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready), .mrsp_id(mrsp_id), .mrsp_data(mrsp_data),
      .rsp0_valid(rsp0_valid), .rsp0_ready(rsp0_ready), .rsp0_id(rsp0_id), .rsp0_data(rsp0_data),
      .rsp1_valid(rsp1_valid), .rsp1_ready(rsp1_ready), .rsp1_id(rsp1_id), .rsp1_data(rsp1_data)
   );

   int checks = 0;
   int errors = 0;

   // bench state for the random phase
   bit              busy     [NTAG];
   int              tag_addr [NTAG];
   int              tag_inc  [NTAG];
   int              mem      [8];
   int              init_val [8];
   int              fq_id    [64];
   int              fq_data  [64];
   int              fq_head = 0, fq_cnt = 0;
   int              rec_addr [NREC];
   int              rec_res  [NREC];
   int              rec_inc  [NREC];
   bit              rec_used [NREC];
   int              nrec = 0;
   int              got = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic take_reply(input int port, input int id, input int data);
      checks++;
      if (!busy[id] || (id % 2) != port) begin
         errors++;
         $display("FAIL R5 reply tag %0d on port %0d: actual busy=%0d parity=%0d expected busy=1 parity=%0d",
                  id, port, busy[id], id % 2, port);
      end
      if (nrec < NREC) begin
         rec_addr[nrec] = tag_addr[id];
         rec_res[nrec]  = data;
         rec_inc[nrec]  = tag_inc[id];
         rec_used[nrec] = 1'b0;
         nrec++;
      end
      busy[id] = 1'b0;
      got++;
   endtask

   initial begin
      int  cyc;
      int  iss0, iss1, nxt0, nxt1;
      bit  acc0, acc1;
      void'($urandom(32'd20240611));

      // ---------------- reset (R9)
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R9 fwd_valid after reset", fwd_valid, 0);
      chk("R9 rsp0_valid after reset", rsp0_valid, 0);
      chk("R9 rsp1_valid after reset", rsp1_valid, 0);
      chk("R9 req0_ready after reset", req0_ready, 1);

      // ---------------- merge of same-address pair (R1, R6)
      fwd_ready = 1'b1;
      req0_valid = 1; req0_id = 0; req0_addr = 3; req0_inc = 5;
      req1_valid = 1; req1_id = 1; req1_addr = 3; req1_inc = 7;
      #1;
      chk("R1 upper ready on merge", req0_ready, 1);
      chk("R1 lower ready on merge", req1_ready, 1);
      tick();
      req0_valid = 0; req1_valid = 0;
      fwd_ready = 1'b0;
      chk("R1 forward valid", fwd_valid, 1);
      chk("R1 forward tag", fwd_id, 0);
      chk("R1 forward addr", fwd_addr, 3);
      chk("R1 forward summed inc", fwd_inc, 12);
      tick();
      chk("R6 forward held valid", fwd_valid, 1);
      chk("R6 forward held inc", fwd_inc, 12);
      fwd_ready = 1'b1;
      tick();
      chk("R6 forward drained", fwd_valid, 0);

      // ---------------- split reply (R4)
      mrsp_valid = 1; mrsp_id = 0; mrsp_data = 100;
      #1;
      chk("R4 merged reply accepted", mrsp_ready, 1);
      tick();
      mrsp_valid = 0;
      chk("R4 upper reply valid", rsp0_valid, 1);
      chk("R4 upper reply tag", rsp0_id, 0);
      chk("R4 upper reply old value", rsp0_data, 100);
      chk("R4 lower reply valid", rsp1_valid, 1);
      chk("R4 lower reply tag", rsp1_id, 1);
      chk("R4 lower reply partial sum", rsp1_data, 105);
      tick();

      // ---------------- different addresses (R2)
      req0_valid = 1; req0_id = 4; req0_addr = 1; req0_inc = 2;
      req1_valid = 1; req1_id = 5; req1_addr = 2; req1_inc = 3;
      #1;
      chk("R2 upper ready", req0_ready, 1);
      chk("R2 lower waits", req1_ready, 0);
      tick();
      req0_valid = 0;
      chk("R2 upper forwarded first", fwd_id, 4);
      #1;
      chk("R2 lower ready next", req1_ready, 1);
      tick();
      req1_valid = 0;
      chk("R2 lower forwarded second tag", fwd_id, 5);
      chk("R2 lower forwarded own inc", fwd_inc, 3);
      tick();

      // ---------------- uncombined replies routed home (R5)
      mrsp_valid = 1; mrsp_id = 5; mrsp_data = 50;
      tick();
      mrsp_id = 4; mrsp_data = 60;
      chk("R5 lower-origin reply on port 1 tag", rsp1_id, 5);
      chk("R5 lower-origin reply data", rsp1_data, 50);
      chk("R5 nothing on port 0", rsp0_valid, 0);
      tick();
      mrsp_valid = 0;
      chk("R5 upper-origin reply on port 0 tag", rsp0_id, 4);
      chk("R5 upper-origin reply data", rsp0_data, 60);
      chk("R5 nothing on port 1", rsp1_valid, 0);
      tick();

      // ---------------- full table stops merging (R3)
      req0_valid = 1; req0_id = 6; req0_addr = 0; req0_inc = 1;
      req1_valid = 1; req1_id = 7; req1_addr = 0; req1_inc = 2;
      tick();
      req0_id = 8; req0_addr = 1; req0_inc = 1;
      req1_id = 9; req1_addr = 1; req1_inc = 2;
      tick();
      req0_id = 10; req0_addr = 2; req0_inc = 4;
      req1_id = 11; req1_addr = 2; req1_inc = 5;
      #1;
      chk("R3 upper ready while full", req0_ready, 1);
      chk("R3 no merge while full", req1_ready, 0);
      tick();
      req0_valid = 0;
      chk("R3 upper alone tag", fwd_id, 10);
      chk("R3 upper alone inc", fwd_inc, 4);
      tick();
      req1_valid = 0;
      chk("R3 lower alone tag", fwd_id, 11);
      chk("R3 lower alone inc", fwd_inc, 5);
      tick();

      // ---------------- reply stall (R7) and further splits (R4)
      rsp0_ready = 0;
      mrsp_valid = 1; mrsp_id = 10; mrsp_data = 1;
      #1;
      chk("R7 reply accepted with port 0 empty", mrsp_ready, 1);
      tick();
      mrsp_id = 6; mrsp_data = 20;
      chk("R7 port 0 loaded", rsp0_id, 10);
      #1;
      chk("R7 merged reply blocked by busy port 0", mrsp_ready, 0);
      tick();
      chk("R7 port 0 held tag", rsp0_id, 10);
      chk("R7 port 0 held data", rsp0_data, 1);
      rsp0_ready = 1;
      tick();
      mrsp_id = 8; mrsp_data = 30;
      chk("R4 upper tag 6", rsp0_id, 6);
      chk("R4 lower value for tag 7", rsp1_data, 21);
      tick();
      mrsp_id = 11; mrsp_data = 40;
      chk("R4 upper value for tag 8", rsp0_data, 30);
      chk("R4 lower tag 9", rsp1_id, 9);
      chk("R4 lower value for tag 9", rsp1_data, 31);
      tick();
      mrsp_valid = 0;
      chk("R5 lower-origin tag 11", rsp1_id, 11);
      chk("R5 lower-origin value", rsp1_data, 40);
      tick();
      tick();

      // ---------------- constrained random traffic (R8, R4, R5)
      for (int a = 0; a < 8; a++) begin
         init_val[a] = a * 100;
         mem[a] = init_val[a];
      end
      for (int t = 0; t < NTAG; t++) busy[t] = 1'b0;
      iss0 = 0; iss1 = 0; nxt0 = 0; nxt1 = 1; acc0 = 0; acc1 = 0; cyc = 0;
      while (got < 2 * NPORT && cyc < LIMIT) begin
         @(negedge clk);
         cyc++;
         if (!req0_valid || acc0) begin
            req0_valid = 0;
            if (iss0 < NPORT && !busy[nxt0] && ($urandom % 3) != 0) begin
               req0_id = nxt0[ID_W-1:0];
               req0_addr = ADDR_W'($urandom % 4);
               req0_inc = DATA_W'(1 + $urandom % 15);
               busy[nxt0] = 1; tag_addr[nxt0] = int'(req0_addr); tag_inc[nxt0] = int'(req0_inc);
               req0_valid = 1; iss0++; nxt0 = (nxt0 + 2) % NTAG;
            end
         end
         if (!req1_valid || acc1) begin
            req1_valid = 0;
            if (iss1 < NPORT && !busy[nxt1] && ($urandom % 3) != 0) begin
               req1_id = nxt1[ID_W-1:0];
               req1_addr = ADDR_W'($urandom % 4);
               req1_inc = DATA_W'(1 + $urandom % 15);
               busy[nxt1] = 1; tag_addr[nxt1] = int'(req1_addr); tag_inc[nxt1] = int'(req1_inc);
               req1_valid = 1; iss1++; nxt1 = (nxt1 + 2) % NTAG;
            end
         end
         fwd_ready  = ($urandom % 4) != 0;
         rsp0_ready = ($urandom % 4) != 0;
         rsp1_ready = ($urandom % 4) != 0;
         mrsp_valid = (fq_cnt > 0) && (($urandom % 3) != 0);
         mrsp_id    = fq_id[fq_head][ID_W-1:0];
         mrsp_data  = fq_data[fq_head][DATA_W-1:0];
         #9;
         acc0 = req0_valid && req0_ready;
         acc1 = req1_valid && req1_ready;
         if (mrsp_valid && mrsp_ready) begin
            fq_head = (fq_head + 1) % 64;
            fq_cnt--;
         end
         if (fwd_valid && fwd_ready) begin
            fq_id[(fq_head + fq_cnt) % 64]   = int'(fwd_id);
            fq_data[(fq_head + fq_cnt) % 64] = mem[fwd_addr];
            fq_cnt++;
            mem[fwd_addr] = (mem[fwd_addr] + int'(fwd_inc)) % 65536;
         end
         if (rsp0_valid && rsp0_ready) take_reply(0, int'(rsp0_id), int'(rsp0_data));
         if (rsp1_valid && rsp1_ready) take_reply(1, int'(rsp1_id), int'(rsp1_data));
      end
      req0_valid = 0; req1_valid = 0; mrsp_valid = 0;

      checks++;
      if (cyc >= LIMIT) begin
         errors++;
         $display("FAIL watchdog: replies actual=%0d expected=%0d", got, 2 * NPORT);
      end

      // serial-order check per address (R8)
      for (int a = 0; a < 4; a++) begin
         int cur, total, cnt;
         bit found;
         cur = init_val[a]; total = init_val[a]; cnt = 0;
         for (int r = 0; r < nrec; r++) begin
            if (rec_addr[r] == a) begin
               cnt++;
               total = total + rec_inc[r];
            end
         end
         for (int k = 0; k < cnt; k++) begin
            found = 0;
            for (int r = 0; r < nrec; r++) begin
               if (!found && !rec_used[r] && rec_addr[r] == a && rec_res[r] == cur) begin
                  rec_used[r] = 1; found = 1; cur = cur + rec_inc[r];
               end
            end
            if (!found) begin
               chk("R8 prefix sum missing", -1, cur);
               break;
            end
         end
         chk("R8 serial order covers every reply", cur, total);
         chk("R8 final memory value", mem[a], total);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule